// File: doc/BRIEF.md
# ATA Task-File Register Interface (Memory-Mapped Mode)

This block is the device-side register file of a removable storage card running in memory-mapped ATA mode. The host bus offers a register-space select, an 11-bit address, byte-wide data and separate single-cycle read and write enables. Each access is decoded onto one of two windows. With the top address bit low, the low four address bits pick a task-file register; address bits 9 to 4 are ignored. With the top address bit high, the whole window reaches the data port, and only bit 0 picks the even or odd byte. Several addresses read one register and write a different one. The busy flag decides whether a command write is accepted.

A small state machine owns the busy flag. It has three states. ST_IDLE is the ready state with busy clear. ST_BUSY is entered from ST_IDLE by the transition "command accepted" and left by the transition "device done". ST_SRST is entered from any state by the transition "soft reset asserted" and left to ST_IDLE by the transition "soft reset released". While the state machine is in ST_BUSY or ST_SRST, busy reads as 1.

The device side supplies the low seven status bits, the error byte, a done pulse and an interrupt-set pulse. The device side receives the task-file contents, a one-cycle command strobe with the command code, and pop and push strobes toward the sector buffer. Read data and all strobes are combinational in the cycle of the access. Register updates take effect at the clock edge that ends that cycle.

Top module: `ata_taskfile_if`

## Requirements
- R1: With address bit 10 low, offsets 2, 3, 4, 5 and 6 (address bits 3:0) are sector count, sector number, cylinder low, cylinder high and drive/head. Each one reads back the last byte written to it, and address bits 9:4 have no effect on the decode. After reset, sector count and sector number hold 0x01 and the other task-file registers hold 0x00.
- R2: Offsets 1 and 0xD both read the error byte and both write the feature register, which is presented on `tf_feature`.
- R3: The status byte is {BSY, DRDY, DF, DSC, DRQ, CORR, IDX, ERR} from bit 7 down to bit 0. Offset 7 and offset 0xE both read this same byte. After reset it reads 0x00, so DRDY is 0.
- R4: When BSY is 0, a write to offset 7 drives `cmd_valid` high for that cycle with `cmd_code` equal to the written byte. BSY is 1 from the next cycle on, and a `dev_done` pulse returns BSY to 0.
- R5: When BSY is 1, a write to offset 7 leaves `cmd_valid` low and does not change the state.
- R6: Data-port accesses are offsets 0, 8 and 9 with bit 10 low, and any address with bit 10 high. When DRQ (status bit 3) is 1, a read returns `buf_rdata` and pulses `buf_pop` for one cycle, and a write pulses `buf_push` with `buf_wdata` equal to the written byte. When DRQ is 0, a read returns 0x00 and neither strobe is raised.
- R7: A `dev_irq_set` pulse sets a pending flag. `irq` equals pending AND NOT nIEN, where nIEN is bit 1 of device control (offset 0xE, write). A read of offset 7 clears the pending flag and a read of offset 0xE does not. A set in the same cycle as an offset-7 read leaves the flag set.
- R8: A write to offset 0xE with bit 2 (SRST) set does the following:
  - sets BSY;
  - returns the task-file registers to their reset values;
  - clears status bits 6:0, the error byte and the pending flag.

  BSY stays 1 until offset 0xE is written with bit 2 clear.
- R9: Offset 0xF reads {1, 1, ~head[3:0], ~drv, drv}, where head is drive/head bits 3:0 and drv is drive/head bit 4. Writes to offset 0xF change nothing.
- R10: An access has no effect when `host_sel` is low or when read and write are both high. When no valid read is in progress, `host_rdata` is 0x00, and reads of offsets 0xA, 0xB and 0xC also return 0x00.
- R11: `dev_stat_we` loads status bits 6:0 from `dev_stat`, and `dev_err_we` loads the error byte from `dev_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Register-space select; accesses count only while high |
| host_addr | input | 11 | Host byte address; bit 10 selects the data window |
| host_rd | input | 1 | Read enable, one cycle per access |
| host_wr | input | 1 | Write enable, one cycle per access |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte (combinational) |
| dev_stat_we | input | 1 | Load status bits 6:0 |
| dev_stat | input | 7 | New status bits 6:0 |
| dev_err_we | input | 1 | Load error byte |
| dev_err | input | 8 | New error byte |
| dev_done | input | 1 | Command finished; clears BSY |
| dev_irq_set | input | 1 | Raise pending interrupt |
| buf_rdata | input | 8 | Byte at the head of the sector buffer |
| buf_pop | output | 1 | Consume one byte from the sector buffer |
| buf_push | output | 1 | Store one byte into the sector buffer |
| buf_wdata | output | 8 | Byte to store |
| cmd_valid | output | 1 | Command accepted this cycle |
| cmd_code | output | 8 | Accepted command byte |
| tf_feature | output | 8 | Feature register |
| tf_count | output | 8 | Sector count |
| tf_sector | output | 8 | Sector number |
| tf_cyl_lo | output | 8 | Cylinder low |
| tf_cyl_hi | output | 8 | Cylinder high |
| tf_drv_head | output | 8 | Drive/head |
| irq | output | 1 | Interrupt request to the host |

## Verification
An offset-7 status read and a device interrupt-set pulse can fall in the same cycle. The read asks for the pending flag to be cleared and the pulse asks for it to be set. The bench provokes this by driving `dev_irq_set` in the very cycle it reads offset 7 with nIEN clear. It then judges the result from `irq` one cycle later, which must still be high, and compares this with a lone offset-7 read, after which `irq` must fall. A second collision is a command write while BSY is held, either by an accepted command or by soft reset. For that case the bench judges `cmd_valid` inside the write cycle and the state through a later status read.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

    // Selected register of the decoded access
    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_DATA,
        SEL_ERRFEAT,
        SEL_COUNT,
        SEL_SECTOR,
        SEL_CYLLO,
        SEL_CYLHI,
        SEL_DRVHD,
        SEL_STATCMD,
        SEL_ALTCTL,
        SEL_DRVADDR
    } tf_sel_e;

    // Busy-ownership states
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BUSY,
        ST_SRST
    } tf_state_e;

    localparam int  BYTE_W     = 8;
    localparam int  STAT_LO_W  = 7;
    localparam int  DRQ_BIT    = 3;
    localparam int  SRST_BIT   = 2;
    localparam int  NIEN_BIT   = 1;
    localparam logic [7:0] COUNT_RST  = 8'h01;
    localparam logic [7:0] SECTOR_RST = 8'h01;

endpackage

// File: rtl/ata_tf_decode.sv
module ata_tf_decode
    import ata_tf_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              host_sel,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_rd,
    input  logic              host_wr,
    output tf_sel_e           which,
    output logic              rd_en,
    output logic              wr_en
);
    localparam int WIN_BIT = ADDR_W - 1;

    logic acc;
    logic unused_hi;

    assign acc       = host_sel & (host_rd ^ host_wr);
    assign rd_en     = acc & host_rd;
    assign wr_en     = acc & host_wr;
    assign unused_hi = ^host_addr[WIN_BIT-1:4];

    always_comb begin
        which = SEL_NONE;
        if (host_addr[WIN_BIT]) begin
            which = SEL_DATA;
        end else begin
            unique case (host_addr[3:0])
                4'h0, 4'h8, 4'h9: which = SEL_DATA;
                4'h1, 4'hD:       which = SEL_ERRFEAT;
                4'h2:             which = SEL_COUNT;
                4'h3:             which = SEL_SECTOR;
                4'h4:             which = SEL_CYLLO;
                4'h5:             which = SEL_CYLHI;
                4'h6:             which = SEL_DRVHD;
                4'h7:             which = SEL_STATCMD;
                4'hE:             which = SEL_ALTCTL;
                4'hF:             which = SEL_DRVADDR;
                default:          which = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/ata_tf_ctrl.sv
module ata_tf_ctrl
    import ata_tf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_wr,
    input  logic ctl_wr,
    input  logic srst_bit,
    input  logic dev_done,
    output logic bsy,
    output logic cmd_ok,
    output logic srst_pulse
);
    tf_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (cmd_wr)               state_nx = ST_BUSY;
            ST_BUSY: if (dev_done)             state_nx = ST_IDLE;
            ST_SRST: if (ctl_wr && !srst_bit)  state_nx = ST_IDLE;
            default:                           state_nx = ST_IDLE;
        endcase
        if (ctl_wr && srst_bit) state_nx = ST_SRST;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        bsy        = (state != ST_IDLE);
        cmd_ok     = cmd_wr && (state == ST_IDLE);
        srst_pulse = ctl_wr && srst_bit;
    end

    // R4
    cmd_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ok |=> bsy);

    // R4
    done_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && dev_done && !ctl_wr) |=> !bsy);

    // R8
    srst_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SRST && !ctl_wr) |=> bsy);

endmodule

// File: rtl/ata_tf_regs.sv
module ata_tf_regs
    import ata_tf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  tf_sel_e              which,
    input  logic                 rd_en,
    input  logic                 wr_en,
    input  logic [BYTE_W-1:0]    wdata,
    input  logic                 srst_pulse,
    input  logic                 bsy,
    input  logic                 dev_stat_we,
    input  logic [STAT_LO_W-1:0] dev_stat,
    input  logic                 dev_err_we,
    input  logic [BYTE_W-1:0]    dev_err,
    input  logic                 dev_irq_set,
    input  logic [BYTE_W-1:0]    buf_rdata,
    output logic [BYTE_W-1:0]    rdata,
    output logic                 buf_pop,
    output logic                 buf_push,
    output logic [BYTE_W-1:0]    tf_feature,
    output logic [BYTE_W-1:0]    tf_count,
    output logic [BYTE_W-1:0]    tf_sector,
    output logic [BYTE_W-1:0]    tf_cyl_lo,
    output logic [BYTE_W-1:0]    tf_cyl_hi,
    output logic [BYTE_W-1:0]    tf_drv_head,
    output logic                 irq
);
    logic [STAT_LO_W-1:0] stat_lo;
    logic [BYTE_W-1:0]    err_q;
    logic                 nien_q;
    logic                 irq_pend;
    logic                 drq;
    logic [BYTE_W-1:0]    status_byte;
    logic [BYTE_W-1:0]    drv_addr;
    logic                 stat_rd;
    logic                 unused_ctl;

    assign drq         = stat_lo[DRQ_BIT];
    assign status_byte = {bsy, stat_lo};
    assign drv_addr    = {2'b11, ~tf_drv_head[3:0], ~tf_drv_head[4], tf_drv_head[4]};
    assign stat_rd     = rd_en && (which == SEL_STATCMD);
    assign unused_ctl  = ^{wdata[BYTE_W-1:SRST_BIT], wdata[0]};

    // Task-file registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tf_feature  <= '0;
            tf_count    <= COUNT_RST;
            tf_sector   <= SECTOR_RST;
            tf_cyl_lo   <= '0;
            tf_cyl_hi   <= '0;
            tf_drv_head <= '0;
        end else if (srst_pulse) begin
            tf_feature  <= '0;
            tf_count    <= COUNT_RST;
            tf_sector   <= SECTOR_RST;
            tf_cyl_lo   <= '0;
            tf_cyl_hi   <= '0;
            tf_drv_head <= '0;
        end else if (wr_en) begin
            unique case (which)
                SEL_ERRFEAT: tf_feature  <= wdata;
                SEL_COUNT:   tf_count    <= wdata;
                SEL_SECTOR:  tf_sector   <= wdata;
                SEL_CYLLO:   tf_cyl_lo   <= wdata;
                SEL_CYLHI:   tf_cyl_hi   <= wdata;
                SEL_DRVHD:   tf_drv_head <= wdata;
                default: ;
            endcase
        end
    end

    // Device-owned status and error, device control, interrupt flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_lo  <= '0;
            err_q    <= '0;
            nien_q   <= 1'b0;
            irq_pend <= 1'b0;
        end else begin
            if (srst_pulse) begin
                stat_lo <= '0;
                err_q   <= '0;
            end else begin
                if (dev_stat_we) stat_lo <= dev_stat;
                if (dev_err_we)  err_q   <= dev_err;
            end
            if (wr_en && which == SEL_ALTCTL) nien_q <= wdata[NIEN_BIT];
            if (srst_pulse)       irq_pend <= 1'b0;
            else if (dev_irq_set) irq_pend <= 1'b1;
            else if (stat_rd)     irq_pend <= 1'b0;
        end
    end

    // Read multiplexer and buffer strobes
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (which)
                SEL_DATA:    rdata = drq ? buf_rdata : '0;
                SEL_ERRFEAT: rdata = err_q;
                SEL_COUNT:   rdata = tf_count;
                SEL_SECTOR:  rdata = tf_sector;
                SEL_CYLLO:   rdata = tf_cyl_lo;
                SEL_CYLHI:   rdata = tf_cyl_hi;
                SEL_DRVHD:   rdata = tf_drv_head;
                SEL_STATCMD: rdata = status_byte;
                SEL_ALTCTL:  rdata = status_byte;
                SEL_DRVADDR: rdata = drv_addr;
                default:     rdata = '0;
            endcase
        end
    end

    assign buf_pop  = rd_en && (which == SEL_DATA) && drq;
    assign buf_push = wr_en && (which == SEL_DATA) && drq;
    assign irq      = irq_pend && !nien_q;

    // R7
    stat_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !dev_irq_set) |=> !irq_pend);

    // R7
    irq_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_irq_set && !srst_pulse) |=> irq_pend);

    // R8
    srst_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srst_pulse |=> (tf_count == COUNT_RST && tf_sector == SECTOR_RST && !irq_pend));

    // R6
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({buf_pop, buf_push}));

endmodule

// File: rtl/ata_taskfile_if.sv
module ata_taskfile_if
    import ata_tf_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              dev_stat_we,
    input  logic [6:0]        dev_stat,
    input  logic              dev_err_we,
    input  logic [7:0]        dev_err,
    input  logic              dev_done,
    input  logic              dev_irq_set,
    input  logic [7:0]        buf_rdata,
    output logic              buf_pop,
    output logic              buf_push,
    output logic [7:0]        buf_wdata,
    output logic              cmd_valid,
    output logic [7:0]        cmd_code,
    output logic [7:0]        tf_feature,
    output logic [7:0]        tf_count,
    output logic [7:0]        tf_sector,
    output logic [7:0]        tf_cyl_lo,
    output logic [7:0]        tf_cyl_hi,
    output logic [7:0]        tf_drv_head,
    output logic              irq
);
    tf_sel_e which;
    logic    rd_en, wr_en;
    logic    bsy, cmd_ok, srst_pulse;

    ata_tf_decode #(.ADDR_W(ADDR_W)) u_dec (
        .host_sel  (host_sel),
        .host_addr (host_addr),
        .host_rd   (host_rd),
        .host_wr   (host_wr),
        .which     (which),
        .rd_en     (rd_en),
        .wr_en     (wr_en)
    );

    ata_tf_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr     (wr_en && which == SEL_STATCMD),
        .ctl_wr     (wr_en && which == SEL_ALTCTL),
        .srst_bit   (host_wdata[SRST_BIT]),
        .dev_done   (dev_done),
        .bsy        (bsy),
        .cmd_ok     (cmd_ok),
        .srst_pulse (srst_pulse)
    );

    ata_tf_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .which       (which),
        .rd_en       (rd_en),
        .wr_en       (wr_en),
        .wdata       (host_wdata),
        .srst_pulse  (srst_pulse),
        .bsy         (bsy),
        .dev_stat_we (dev_stat_we),
        .dev_stat    (dev_stat),
        .dev_err_we  (dev_err_we),
        .dev_err     (dev_err),
        .dev_irq_set (dev_irq_set),
        .buf_rdata   (buf_rdata),
        .rdata       (host_rdata),
        .buf_pop     (buf_pop),
        .buf_push    (buf_push),
        .tf_feature  (tf_feature),
        .tf_count    (tf_count),
        .tf_sector   (tf_sector),
        .tf_cyl_lo   (tf_cyl_lo),
        .tf_cyl_hi   (tf_cyl_hi),
        .tf_drv_head (tf_drv_head),
        .irq         (irq)
    );

    assign cmd_valid = cmd_ok;
    assign cmd_code  = host_wdata;
    assign buf_wdata = host_wdata;

    // R5
    busy_drops_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bsy && host_sel && host_wr && !host_rd && !host_addr[ADDR_W-1]
         && host_addr[3:0] == 4'h7) |-> !cmd_valid);

    // R10
    no_sel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_sel |-> (host_rdata == 8'h00 && !buf_pop && !buf_push && !cmd_valid));

endmodule

// File: tb/sim_ata_taskfile_if.sv
module sim_ata_taskfile_if;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_sel = 1'b0;
    logic [10:0] host_addr = '0;
    logic        host_rd = 1'b0, host_wr = 1'b0;
    logic [7:0]  host_wdata = '0, host_rdata;
    logic        dev_stat_we = 1'b0;
    logic [6:0]  dev_stat = '0;
    logic        dev_err_we = 1'b0;
    logic [7:0]  dev_err = '0;
    logic        dev_done = 1'b0, dev_irq_set = 1'b0;
    logic [7:0]  buf_rdata = 8'hA5;
    logic        buf_pop, buf_push, cmd_valid, irq;
    logic [7:0]  buf_wdata, cmd_code;
    logic [7:0]  tf_feature, tf_count, tf_sector, tf_cyl_lo, tf_cyl_hi, tf_drv_head;

    int checks = 0, fails = 0;
    logic [7:0] s_rdata;
    logic       s_pop, s_push, s_cmdv;
    logic [7:0] s_cmdc, s_bwd;
    logic [7:0] model [2:6];

    always #4 clk = ~clk;

    ata_taskfile_if u0 (.*);

    function automatic logic [7:0] exp_drvaddr(input logic [7:0] dh);
        return {2'b11, ~dh[3:0], ~dh[4], dh[4]};
    endfunction

    function automatic logic [10:0] mk_addr(input logic [3:0] off);
        return {1'b0, 6'($urandom % 64), off};
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
        end
    endtask

    task automatic access(input logic sel, input logic [10:0] a, input logic rd,
                          input logic wr, input logic [7:0] wd, input logic irqset);
        @(negedge clk);
        host_sel = sel; host_addr = a; host_rd = rd; host_wr = wr;
        host_wdata = wd; dev_irq_set = irqset;
        #2;
        s_rdata = host_rdata; s_pop = buf_pop; s_push = buf_push;
        s_cmdv = cmd_valid; s_cmdc = cmd_code; s_bwd = buf_wdata;
        @(negedge clk);
        host_sel = 1'b0; host_rd = 1'b0; host_wr = 1'b0; dev_irq_set = 1'b0;
    endtask

    task automatic rd(input logic [3:0] off);
        access(1'b1, mk_addr(off), 1'b1, 1'b0, 8'h00, 1'b0);
    endtask

    task automatic wr(input logic [3:0] off, input logic [7:0] v);
        access(1'b1, mk_addr(off), 1'b0, 1'b1, v, 1'b0);
    endtask

    task automatic dev_status(input logic [6:0] v);
        @(negedge clk); dev_stat_we = 1'b1; dev_stat = v;
        @(negedge clk); dev_stat_we = 1'b0;
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0A7A));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        rd(4'h7);  check("R3 reset status", s_rdata, 8'h00);
        check("R1 reset count", tf_count, 8'h01);
        check("R1 reset sector", tf_sector, 8'h01);
        rd(4'hF);  check("R9 reset drive addr", s_rdata, 8'hFE);
        check("R7 reset irq", {7'd0, irq}, 8'h00);

        // R1 random task-file traffic with random upper address bits
        for (int i = 2; i <= 6; i++) model[i] = (i < 4) ? 8'h01 : 8'h00;
        for (int i = 0; i < 80; i++) begin
            logic [3:0] off;
            logic [7:0] v;
            off = 4'(2 + $urandom % 5);
            v   = 8'($urandom);
            if ($urandom % 2) begin
                wr(off, v);
                model[off] = v;
            end
            rd(off);
            check("R1 readback", s_rdata, model[off]);
        end

        // R11 R3 device status, alternate status
        dev_status(7'h50);
        rd(4'h7); check("R11 status", s_rdata, 8'h50);
        rd(4'hE); check("R3 alt status", s_rdata, 8'h50);

        // R2 error / feature aliases
        @(negedge clk); dev_err_we = 1'b1; dev_err = 8'h04;
        @(negedge clk); dev_err_we = 1'b0;
        rd(4'h1); check("R2 error", s_rdata, 8'h04);
        rd(4'hD); check("R2 dup error", s_rdata, 8'h04);
        wr(4'h1, 8'h3C); check("R2 feature", tf_feature, 8'h3C);
        wr(4'hD, 8'h7E); check("R2 dup feature", tf_feature, 8'h7E);

        // R4 R5 command acceptance and BSY gating
        wr(4'h7, 8'hEC);
        check("R4 cmd_valid", {7'd0, s_cmdv}, 8'h01);
        check("R4 cmd_code", s_cmdc, 8'hEC);
        rd(4'h7); check("R4 busy after cmd", {7'd0, s_rdata[7]}, 8'h01);
        wr(4'h7, 8'h20);
        check("R5 cmd dropped", {7'd0, s_cmdv}, 8'h00);
        @(negedge clk); dev_done = 1'b1;
        @(negedge clk); dev_done = 1'b0;
        rd(4'h7); check("R4 done clears busy", s_rdata, 8'h50);
        check("R5 no second cmd state", {7'd0, s_rdata[7]}, 8'h00);

        // R6 data window
        rd(4'h0); check("R6 no drq read", s_rdata, 8'h00);
        check("R6 no drq pop", {7'd0, s_pop}, 8'h00);
        wr(4'h8, 8'h11); check("R6 no drq push", {7'd0, s_push}, 8'h00);
        dev_status(7'h58);
        for (int i = 0; i < 12; i++) begin
            logic [10:0] a;
            logic        w;
            case (i % 4)
                0: a = mk_addr(4'h0);
                1: a = mk_addr(4'h8);
                2: a = mk_addr(4'h9);
                default: a = {1'b1, 10'($urandom)};
            endcase
            w = 1'($urandom % 2);
            buf_rdata = 8'($urandom);
            if (w) begin
                access(1'b1, a, 1'b0, 1'b1, 8'(i * 7 + 3), 1'b0);
                check("R6 push", {7'd0, s_push}, 8'h01);
                check("R6 push data", s_bwd, 8'(i * 7 + 3));
                check("R6 push no pop", {7'd0, s_pop}, 8'h00);
            end else begin
                access(1'b1, a, 1'b1, 1'b0, 8'h00, 1'b0);
                check("R6 pop", {7'd0, s_pop}, 8'h01);
                check("R6 read data", s_rdata, buf_rdata);
            end
        end

        // R10 unmapped offsets, deselect, double enable
        rd(4'hB); check("R10 unmapped read", s_rdata, 8'h00);
        access(1'b0, mk_addr(4'h2), 1'b0, 1'b1, 8'h99, 1'b0);
        access(1'b0, mk_addr(4'h7), 1'b1, 1'b0, 8'h00, 1'b0);
        check("R10 deselected read", s_rdata, 8'h00);
        access(1'b1, mk_addr(4'h3), 1'b1, 1'b1, 8'h77, 1'b0);
        rd(4'h2); check("R10 deselected write", s_rdata, model[2]);
        rd(4'h3); check("R10 double enable", s_rdata, model[3]);

        // R9 drive address
        wr(4'h6, 8'h15);
        rd(4'hF); check("R9 drive addr", s_rdata, exp_drvaddr(8'h15));
        wr(4'hF, 8'h00);
        rd(4'hF); check("R9 write ignored", s_rdata, 8'hE9);

        // R7 interrupt
        wr(4'hE, 8'h00);
        @(negedge clk); dev_irq_set = 1'b1;
        @(negedge clk); dev_irq_set = 1'b0;
        check("R7 irq raised", {7'd0, irq}, 8'h01);
        rd(4'hE); check("R7 alt read keeps", {7'd0, irq}, 8'h01);
        wr(4'hE, 8'h02); check("R7 nIEN masks", {7'd0, irq}, 8'h00);
        wr(4'hE, 8'h00); check("R7 unmask", {7'd0, irq}, 8'h01);
        access(1'b1, mk_addr(4'h7), 1'b1, 1'b0, 8'h00, 1'b1);
        check("R7 set beats clear", {7'd0, irq}, 8'h01);
        rd(4'h7); check("R7 status read clears", {7'd0, irq}, 8'h00);

        // R8 soft reset
        @(negedge clk); dev_irq_set = 1'b1;
        @(negedge clk); dev_irq_set = 1'b0;
        wr(4'hE, 8'h04);
        rd(4'h7); check("R8 srst busy", {7'd0, s_rdata[7]}, 8'h01);
        check("R8 count", tf_count, 8'h01);
        check("R8 sector", tf_sector, 8'h01);
        check("R8 drive/head", tf_drv_head, 8'h00);
        check("R8 feature", tf_feature, 8'h00);
        check("R8 irq cleared", {7'd0, irq}, 8'h00);
        wr(4'h7, 8'hEC); check("R5 cmd in srst", {7'd0, s_cmdv}, 8'h00);
        wr(4'hE, 8'h00);
        rd(4'h7); check("R8 released", s_rdata, 8'h00);

        finish_run();
    end
endmodule